// File: doc/BRIEF.md
# Transparent Character-Synchronized Serial Receiver

This block turns a raw serial data line into 8-bit characters with no link-layer processing: no flag hunting, no bit destuffing and no check sequence. It advances one bit time on each clock where `bit_en_i` is high. Character boundaries come from the shared `sync_i` input, which acts in one of two ways.

In strobe mode, `sync_i` is a level strobe that gates which bit times are taken. In time-slot mode, `sync_i` marks a frame start. A programmed bit offset and a programmed slot length in bytes then select the bits to capture, and both values are reloaded at each frame start.

Every completed character lands in a holding register, and a one-clock valid pulse marks the update. When the receive mode selector is all ones, each character is also pushed into a show-ahead receive FIFO. A push that finds the FIFO full is dropped, and a sticky overflow flag records the loss.

Top module: `char_sync_rx`

## Requirements
- R1: After reset, `hold_o` is 0x00, `char_vld_o` is 0, `fifo_empty_o` is 1, `fifo_full_o` is 0 and `fifo_ovf_o` is 0.
- R2: Bits are assembled LSB first: the first sampled bit becomes bit 0. After the 8th sampled bit, `hold_o` takes the character and `char_vld_o` is high for exactly the one following clock.
- R3: Strobe mode is `clk_mode_i`=0. In this mode a bit is sampled only when `bit_en_i` and `sync_i` are both 1. Other bit times are ignored, and a partial character is kept across them.
- R4: Time-slot mode is `clk_mode_i`=1. A bit time with `sync_i`=1 starts a frame. The next `slot_off_i` bit times are skipped, the following `slot_len_i`×8 bit times are sampled, and later bit times are ignored until the next frame start.
- R5: A frame start discards any partial character and restarts assembly at bit 0.
- R6: In time-slot mode, a frame with `slot_len_i`=0 receives nothing.
- R7: Data passes unaltered, including 0x7E, 0xFF and runs of five or more ones.
- R8: A character is pushed into the FIFO only when `rx_mode_i` equals 3'b111.
- R9: The FIFO is show-ahead: `fifo_data_o` shows the oldest entry, and `fifo_rd_i`=1 pops it when the FIFO is not empty. A pop on an empty FIFO has no effect.
- R10: A push that finds the FIFO full (checked before any same-cycle pop) is dropped. It sets `fifo_ovf_o`, which stays set until reset.
- R11: `hold_o` keeps the last character unchanged between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One bit time per high cycle |
| rxd_i | input | 1 | Serial receive data |
| sync_i | input | 1 | Receive strobe (strobe mode) or frame sync (time-slot mode) |
| clk_mode_i | input | 1 | 0 strobe mode, 1 time-slot mode |
| rx_mode_i | input | 3 | 3'b111 enables FIFO pushes |
| slot_off_i | input | OFF_W | Bit offset from frame start |
| slot_len_i | input | LEN_W | Slot length in bytes |
| hold_o | output | 8 | Last received character |
| char_vld_o | output | 1 | One-clock pulse when `hold_o` updates |
| fifo_rd_i | input | 1 | FIFO pop |
| fifo_data_o | output | 8 | Oldest FIFO entry |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_full_o | output | 1 | FIFO full |
| fifo_ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with `FIFO_DEPTH`=4, `OFF_W`=4 and `LEN_W`=3. The shallow FIFO means five characters are enough to drive it into overflow, so the full-drop and sticky-flag paths are reached within a short run. The narrow offset and length fields keep time-slot frames short, so one run covers a zero offset, a zero-length slot, multi-byte slots, trailing ignored bits and a mid-character resync.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  typedef enum logic {
    SYNC_STROBE = 1'b0,
    SYNC_SLOT   = 1'b1
  } sync_mode_e;

  localparam int unsigned CHAR_W = 8;
  localparam logic [2:0] FIFO_MODE = 3'b111;
endpackage

// File: rtl/rx_slot_timer.sv
module rx_slot_timer
  import csrx_pkg::*;
#(
  parameter int unsigned OFF_W = 10,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             sync_i,
  input  sync_mode_e       mode_i,
  input  logic [OFF_W-1:0] slot_off_i,
  input  logic [LEN_W-1:0] slot_len_i,
  output logic             sample_o,
  output logic             restart_o
);
  localparam int unsigned BITS_W = LEN_W + 3;

  logic [OFF_W-1:0]  skip_q;
  logic [BITS_W-1:0] left_q;
  logic              frame_sync;

  assign frame_sync = bit_en_i && sync_i && (mode_i == SYNC_SLOT);
  assign restart_o  = frame_sync;

  always_comb begin
    if (mode_i == SYNC_STROBE) sample_o = bit_en_i && sync_i;
    else sample_o = bit_en_i && !sync_i && (skip_q == '0) && (left_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q <= '0;
      left_q <= '0;
    end else if (frame_sync) begin
      skip_q <= slot_off_i;
      left_q <= {slot_len_i, 3'b000};
    end else if (bit_en_i && mode_i == SYNC_SLOT) begin
      if (skip_q != '0) skip_q <= skip_q - 1'b1;
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  // R3: strobe mode takes a bit only under an active strobe
  a_r3_strobe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && mode_i == SYNC_STROBE) |-> (sync_i && bit_en_i));
  // R4: no sampling while the offset is still running
  a_r4_skip_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SYNC_SLOT && skip_q != '0) |-> !sample_o);
endmodule

// File: rtl/rx_char_asm.sv
module rx_char_asm
  import csrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              restart_i,
  input  logic              rxd_i,
  output logic [CHAR_W-1:0] hold_o,
  output logic              vld_o
);
  localparam int unsigned CNT_W = $clog2(CHAR_W);

  logic [CHAR_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CHAR_W-1:0] shift_nxt;

  assign shift_nxt = {rxd_i, shift_q[CHAR_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      hold_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (restart_i) begin
        cnt_q <= '0;
      end else if (sample_i) begin
        shift_q <= shift_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(CHAR_W - 1)) begin
          hold_o <= shift_nxt;
          vld_o  <= 1'b1;
        end
      end
    end
  end

  // R2: a character needs 8 samples, so the pulse cannot repeat
  a_r2_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  // R11: holding register only moves with the valid pulse
  a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(hold_o));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_acc, pop_acc;

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CW'(DEPTH));
  assign push_acc = push_i && !full_o;
  assign pop_acc  = pop_i && !empty_o;
  assign dout_o   = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (push_acc && wr_ptr_q == AW'(i)) mem_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (push_acc) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_acc)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_acc, pop_acc})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end

  // R10: a push into a full FIFO leaves the flag raised
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> ovf_o);
  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R9: popping an empty FIFO does not underflow
  a_r9_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/char_sync_rx.sv
module char_sync_rx
  import csrx_pkg::*;
#(
  parameter int unsigned OFF_W      = 10,
  parameter int unsigned LEN_W      = 6,
  parameter int unsigned FIFO_DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             rxd_i,
  input  logic             sync_i,
  input  logic             clk_mode_i,
  input  logic [2:0]       rx_mode_i,
  input  logic [OFF_W-1:0] slot_off_i,
  input  logic [LEN_W-1:0] slot_len_i,
  output logic [7:0]       hold_o,
  output logic             char_vld_o,
  input  logic             fifo_rd_i,
  output logic [7:0]       fifo_data_o,
  output logic             fifo_empty_o,
  output logic             fifo_full_o,
  output logic             fifo_ovf_o
);
  logic       sample, restart;
  sync_mode_e mode;

  assign mode = sync_mode_e'(clk_mode_i);

  rx_slot_timer #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .sync_i     (sync_i),
    .mode_i     (mode),
    .slot_off_i (slot_off_i),
    .slot_len_i (slot_len_i),
    .sample_o   (sample),
    .restart_o  (restart)
  );

  rx_char_asm u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample),
    .restart_i (restart),
    .rxd_i     (rxd_i),
    .hold_o    (hold_o),
    .vld_o     (char_vld_o)
  );

  rx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (char_vld_o && rx_mode_i == FIFO_MODE),
    .din_i   (hold_o),
    .pop_i   (fifo_rd_i),
    .dout_o  (fifo_data_o),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full_o),
    .ovf_o   (fifo_ovf_o)
  );

  // R8: FIFO fills only in the FIFO receive mode
  a_r8_push_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mode_i != FIFO_MODE && !fifo_rd_i) |=> $stable(fifo_empty_o));
endmodule

// File: tb/tb_char_sync_rx.sv
module tb_char_sync_rx;
  localparam int unsigned OFF_W = 4;
  localparam int unsigned LEN_W = 3;
  localparam int unsigned DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, rxd = 0, sync = 0, clk_mode = 0, fifo_rd = 0;
  logic [2:0] rx_mode = 3'b000;
  logic [OFF_W-1:0] slot_off = '0;
  logic [LEN_W-1:0] slot_len = '0;
  logic [7:0] hold, fifo_data;
  logic char_vld, fifo_empty, fifo_full, fifo_ovf;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] last_char = 8'h00;

  always #5 clk = ~clk;

  char_sync_rx #(.OFF_W(OFF_W), .LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .rxd_i(rxd), .sync_i(sync),
    .clk_mode_i(clk_mode), .rx_mode_i(rx_mode), .slot_off_i(slot_off),
    .slot_len_i(slot_len), .hold_o(hold), .char_vld_o(char_vld),
    .fifo_rd_i(fifo_rd), .fifo_data_o(fifo_data), .fifo_empty_o(fifo_empty),
    .fifo_full_o(fifo_full), .fifo_ovf_o(fifo_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic s, input logic d);
    @(negedge clk);
    bit_en = en; sync = s; rxd = d;
  endtask

  task automatic expect_char(input logic [7:0] b, input string req);
    exp_q.push_back(b);
    tag_q.push_back(req);
    last_char = b;
  endtask

  // strobe-mode character, optionally with ignored bit times between bits
  task automatic strobe_char(input logic [7:0] b, input bit gaps, input string req);
    expect_char(b, req);
    for (int i = 0; i < 8; i++) begin
      drive(1, 1, b[i]);
      if (gaps) begin
        drive(1, 0, ~b[i]);
        drive(0, 1, ~b[i]);
      end
    end
  endtask

  task automatic slot_frame_start(input int off, input int len);
    slot_off = OFF_W'(off);
    slot_len = LEN_W'(len);
    drive(1, 1, 1'b1);
    for (int i = 0; i < off; i++) drive(1, 0, i[0]);
  endtask

  task automatic slot_char(input logic [7:0] b, input string req);
    expect_char(b, req);
    for (int i = 0; i < 8; i++) drive(1, 0, b[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 1'b0);
  endtask

  task automatic pop_check(input logic [7:0] b, input string req);
    @(negedge clk);
    check(!fifo_empty && fifo_data == b, req, fifo_data, b);
    fifo_rd = 1;
    @(negedge clk);
    fifo_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    last_char = 8'h00;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && char_vld) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected char", hold, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(hold == e, t, hold, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(hold == 8'h00 && !char_vld, "R1 hold/vld", {char_vld, hold}, 0);
    check(fifo_empty && !fifo_full && !fifo_ovf, "R1 fifo flags",
          {fifo_empty, fifo_full, fifo_ovf}, 3'b100);

    // R2 timing: pulse in the clock after the 8th bit, then low
    strobe_char(8'h3C, 0, "R2 lsb first");
    drive(0, 0, 0);
    check(char_vld == 1'b1, "R2 vld pulse", char_vld, 1);
    drive(0, 0, 0);
    check(char_vld == 1'b0, "R2 vld single", char_vld, 0);

    // R3: gaps with strobe low or no bit enable are ignored
    strobe_char(8'hA5, 1, "R3 strobe gaps");
    strobe_char(8'h96, 1, "R3 strobe gaps 2");
    // R7: framing-like patterns pass untouched
    strobe_char(8'h7E, 0, "R7 flag pattern");
    strobe_char(8'hFF, 0, "R7 all ones");
    strobe_char(8'h1F, 0, "R7 five ones");
    strobe_char(8'hF8, 0, "R7 five ones high");
    idle(2);
    // R11: hold retains with strobe low activity
    for (int i = 0; i < 20; i++) drive(1, 0, i[0]);
    idle(2);
    check(hold == 8'hF8, "R11 hold retained", hold, 8'hF8);

    // R4: time-slot frames
    clk_mode = 1;
    slot_frame_start(5, 2);
    slot_char(8'h12, "R4 slot byte0");
    slot_char(8'h34, "R4 slot byte1");
    for (int i = 0; i < 12; i++) drive(1, 0, 1'b1);  // after slot: ignored
    idle(2);
    check(hold == 8'h34, "R4 trailing ignored", hold, 8'h34);
    slot_frame_start(0, 1);
    slot_char(8'hC3, "R4 zero offset");
    for (int i = 0; i < 9; i++) drive(1, 0, 1'b0);
    idle(2);

    // R5: resync mid character
    slot_frame_start(2, 2);
    for (int i = 0; i < 5; i++) drive(1, 0, 1'b1);
    slot_frame_start(1, 1);
    slot_char(8'h5A, "R5 resync");
    idle(2);

    // R6: zero-length slot
    slot_frame_start(0, 0);
    for (int i = 0; i < 16; i++) drive(1, 0, i[1]);
    idle(2);
    check(hold == 8'h5A, "R6 empty slot", hold, 8'h5A);

    // R8: no push outside FIFO mode
    clk_mode = 0;
    rx_mode = 3'b110;
    strobe_char(8'h81, 0, "R8 hold only");
    strobe_char(8'h42, 0, "R8 hold only 2");
    idle(2);
    check(fifo_empty == 1'b1, "R8 no push", fifo_empty, 1);

    // R9: FIFO order and show-ahead
    rx_mode = 3'b111;
    strobe_char(8'h11, 0, "R9 push");
    strobe_char(8'h22, 0, "R9 push");
    strobe_char(8'h33, 0, "R9 push");
    idle(2);
    pop_check(8'h11, "R9 pop0");
    pop_check(8'h22, "R9 pop1");
    pop_check(8'h33, "R9 pop2");
    check(fifo_empty == 1'b1, "R9 drained", fifo_empty, 1);
    @(negedge clk); fifo_rd = 1;
    @(negedge clk); fifo_rd = 0;
    strobe_char(8'h44, 0, "R9 after empty pop");
    idle(2);
    check(!fifo_empty && fifo_data == 8'h44, "R9 empty pop ignored", fifo_data, 8'h44);
    pop_check(8'h44, "R9 pop3");

    // R10: overflow drop and sticky flag
    check(fifo_ovf == 1'b0, "R10 no ovf yet", fifo_ovf, 0);
    for (int i = 0; i < 5; i++) strobe_char(8'hA0 + 8'(i), 0, "R10 fill");
    idle(2);
    check(fifo_full && fifo_ovf, "R10 full ovf", {fifo_full, fifo_ovf}, 2'b11);
    for (int i = 0; i < 4; i++) pop_check(8'hA0 + 8'(i), "R10 kept order");
    check(fifo_empty == 1'b1, "R10 fifth dropped", fifo_empty, 1);
    check(fifo_ovf == 1'b1, "R10 sticky", fifo_ovf, 1);
    do_reset();
    @(negedge clk);
    check(fifo_ovf == 1'b0 && hold == 8'h00, "R1 reset clears", {fifo_ovf, hold}, 0);

    check(exp_q.size() == 0, "R2 missing chars", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule